// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer with Lock Detection

This block takes a single serial bit stream, sampled once per bit by a recovered bit-rate clock, and turns it into 10-bit parallel words. Every 12-bit frame on the line carries a start clock bit (1), ten data bits sent least-significant first, and a stop clock bit (0). The block does not know where frames begin. It watches every bit offset at once, and it declares lock when one offset shows a valid pair of clock bits in enough consecutive frames. A transmitter can also send a dedicated sync frame, and the block aligns to that frame at once.

While locked, the block delivers one word per good frame together with a one-cycle strobe. The lock flag is active low. It is high from reset, low while locked, and high again after a run of frames with broken clock bits. The data outputs stay in high impedance from reset until the first lock. After that they are always driven, and they hold the last good word.

The control core has three states. ST_ACQUIRE is the state after reset: the block has never locked and the outputs float. ST_LOCKED means aligned and delivering words. ST_REHUNT means lock was lost and the block is searching again. There are three transitions. T_FIRST_LOCK goes from ST_ACQUIRE to ST_LOCKED on an alignment hit. T_LOSS goes from ST_LOCKED to ST_REHUNT once LOSS_CNT consecutive frames have bad clock bits. T_RELOCK goes from ST_REHUNT to ST_LOCKED on an alignment hit.

Top module: `emb_frame_deser`

## Requirements
- R1: A frame is 12 bits in arrival order: start bit 1, data bits d0 to d9 (d0 first), stop bit 0. Each output word equals d9..d0 of one frame.
- R2: `lock_n` is 1 from reset until the first lock. It is 0 throughout ST_LOCKED.
- R3: `dout` is high impedance from reset until the first lock. From then on it is driven, including after lock is lost, and it holds the last delivered word.
- R4: On ordinary data, lock is declared when LOCK_CNT (default 4) consecutive frames at the same bit offset have start=1 and stop=0. `lock_n` falls one cycle after the stop bit of the last of these frames is sampled.
- R5: A sync frame forces lock one cycle after its last bit is sampled, without waiting for LOCK_CNT frames. A sync frame is six 1 bits followed by six 0 bits, which gives data 0x01F.
- R6: The frame that completes alignment produces no word. Each later good frame produces one word with a `dvalid` pulse lasting exactly one cycle, registered one cycle after its stop bit is sampled.
- R7: While locked, a frame with bad clock bits produces no strobe and leaves `dout` unchanged. Fewer than LOSS_CNT consecutive bad frames keep the lock, and one good frame clears the run.
- R8: LOSS_CNT (default 2) consecutive bad frames raise `lock_n` one cycle after the last one's stop bit is sampled. Hunting then restarts from scratch at every offset.
- R9: `dvalid` is never 1 while `lock_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Serial line bit, one per clock |
| dout | output | 10 | Recovered data word, high impedance before first lock |
| dvalid | output | 1 | One-cycle strobe per delivered word |
| lock_n | output | 1 | Low while locked, high otherwise |

## Verification
The assertions take for granted that `ser_bit` changes only away from the rising edge and that exactly one bit arrives per clock with no gaps. Under that condition, frame boundaries recur every twelve cycles and a change of `lock_n` can always be traced to the window just sampled. The stimulus drives one bit per falling edge and never pauses the stream once frames start. Before the first lock, it uses idle zeros and frames of the form 1111 followed by eight 0s. That pattern has only one 0-to-1 transition, so no false offset can gather matches and no window in it equals the sync pattern.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam int FRAME_BITS = 12;
    localparam int DATA_BITS  = 10;
    localparam int PH_W       = $clog2(FRAME_BITS);

    // Six ones arrive first: bit 0 of the window is the oldest bit.
    localparam logic [FRAME_BITS-1:0] SYNC_PATTERN = 12'h03F;

    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_REHUNT  = 2'd2
    } lock_state_t;

endpackage

// File: rtl/frm_shifter.sv
module frm_shifter
    import frm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_bit,
    output logic [FRAME_BITS-1:0] win,
    output logic [PH_W-1:0]       phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_BITS - 1);

    // Newest bit enters at the top, so win[0] is the oldest of twelve.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win   <= '0;
            phase <= '0;
        end else begin
            win   <= {ser_bit, win[FRAME_BITS-1:1]};
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/frm_aligner.sv
module frm_aligner
    import frm_pkg::*;
#(
    parameter int LOCK_CNT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hunt_en,
    input  logic [FRAME_BITS-1:0] win,
    input  logic [PH_W-1:0]       phase,
    output logic                  align_hit
);

    localparam int CW = $clog2(LOCK_CNT + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(LOCK_CNT - 1);

    logic                  clk_ok;
    logic                  sync_hit;
    logic [FRAME_BITS-1:0] off_hit;

    assign clk_ok   = win[0] & ~win[FRAME_BITS-1];
    assign sync_hit = (win == SYNC_PATTERN);

    // One run-length counter for each candidate bit offset.
    for (genvar g = 0; g < FRAME_BITS; g++) begin : g_off
        logic [CW-1:0] run_q;
        logic          at_me;

        assign at_me      = (phase == PH_W'(g));
        assign off_hit[g] = at_me && clk_ok && (int'(run_q) + 1 >= LOCK_CNT);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (!hunt_en) begin
                run_q <= '0;
            end else if (at_me) begin
                if (!clk_ok)
                    run_q <= '0;
                else if (run_q != CNT_TOP)
                    run_q <= run_q + 1'b1;
            end
        end

        // R4: an offset is never credited beyond the acquire threshold
        p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(run_q) < LOCK_CNT);
    end

    assign align_hit = hunt_en && (sync_hit || (|off_hit));

endmodule

// File: rtl/frm_lock_fsm.sv
module frm_lock_fsm
    import frm_pkg::*;
#(
    parameter int LOSS_CNT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] win,
    input  logic [PH_W-1:0]       phase,
    input  logic                  align_hit,
    output logic                  hunt_en,
    output logic [DATA_BITS-1:0]  word_q,
    output logic                  dvalid_q,
    output logic                  drive_q,
    output logic                  lock_n
);

    localparam int MW = $clog2(LOSS_CNT + 1);

    lock_state_t     state_q, state_d;
    logic [PH_W-1:0] lock_ph_q;
    logic [MW-1:0]   miss_q;
    logic            clk_ok;
    logic            at_frame;
    logic            loss_now;

    assign clk_ok   = win[0] & ~win[FRAME_BITS-1];
    assign at_frame = (state_q == ST_LOCKED) && (phase == lock_ph_q);
    assign loss_now = at_frame && !clk_ok && (int'(miss_q) + 1 >= LOSS_CNT);

    // Next state: T_FIRST_LOCK, T_LOSS, T_RELOCK.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: if (align_hit) state_d = ST_LOCKED;
            ST_LOCKED:  if (loss_now)  state_d = ST_REHUNT;
            ST_REHUNT:  if (align_hit) state_d = ST_LOCKED;
            default:                   state_d = ST_ACQUIRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    // Registered outputs and per-lock bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_ph_q <= '0;
            miss_q    <= '0;
            word_q    <= '0;
            dvalid_q  <= 1'b0;
            drive_q   <= 1'b0;
        end else begin
            dvalid_q <= 1'b0;
            if (state_q != ST_LOCKED) begin
                if (align_hit) begin
                    lock_ph_q <= phase;
                    miss_q    <= '0;
                    drive_q   <= 1'b1;
                end
            end else if (at_frame) begin
                if (clk_ok) begin
                    word_q   <= win[DATA_BITS:1];
                    dvalid_q <= 1'b1;
                    miss_q   <= '0;
                end else if (int'(miss_q) < LOSS_CNT) begin
                    miss_q <= miss_q + 1'b1;
                end
            end
        end
    end

    assign hunt_en = (state_q != ST_LOCKED);
    assign lock_n  = (state_q != ST_LOCKED);

    // R4 / R5: lock only ever follows a window with valid clock bits
    p_lock_on_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(win[0] && !win[FRAME_BITS-1]));

    // R8: lock is only dropped right after a frame with broken clock bits
    p_loss_on_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> $past(!(win[0] && !win[FRAME_BITS-1])));

    // R6: the word strobe lasts a single cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_q |=> !dvalid_q);

    // R9: no strobe outside the locked state
    p_valid_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_q |-> !lock_n);

    // R7: the output word only moves together with a strobe
    p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid_q |-> $stable(word_q));

    // R3: once driven, the outputs never float again
    p_drive_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drive_q) |-> drive_q);

endmodule

// File: rtl/emb_frame_deser.sv
module emb_frame_deser
    import frm_pkg::*;
#(
    parameter int LOCK_CNT = 4,
    parameter int LOSS_CNT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_bit,
    output logic [DATA_BITS-1:0] dout,
    output logic                 dvalid,
    output logic                 lock_n
);

    logic [FRAME_BITS-1:0] win;
    logic [PH_W-1:0]       phase;
    logic                  hunt_en;
    logic                  align_hit;
    logic [DATA_BITS-1:0]  word_q;
    logic                  drive_q;

    frm_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .win     (win),
        .phase   (phase)
    );

    frm_aligner #(.LOCK_CNT(LOCK_CNT)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .hunt_en   (hunt_en),
        .win       (win),
        .phase     (phase),
        .align_hit (align_hit)
    );

    frm_lock_fsm #(.LOSS_CNT(LOSS_CNT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .phase     (phase),
        .align_hit (align_hit),
        .hunt_en   (hunt_en),
        .word_q    (word_q),
        .dvalid_q  (dvalid),
        .drive_q   (drive_q),
        .lock_n    (lock_n)
    );

    assign dout = drive_q ? word_q : {DATA_BITS{1'bz}};

endmodule

// File: tb/emb_frame_deser_tb.sv
module emb_frame_deser_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic [9:0] dout;
    logic       dvalid;
    logic       lock_n;

    int n_checks = 0;
    int n_errors = 0;
    int nbits = 0;
    bit done = 1'b0;

    // Monitor records
    int   cap_word [32];
    int   cap_stamp[32];
    int   ncap = 0;
    int   fall_stamp[8];
    int   nfall = 0;
    int   rise_stamp[8];
    int   nrise = 0;
    bit   prev_lock_n = 1'b1;
    bit   ever_locked = 1'b0;
    int   z_bad = 0;
    int   valid_bad = 0;

    localparam int NTBL = 8;
    localparam logic [9:0] TBL [NTBL] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA,
                                          10'h001, 10'h200, 10'h0F0, 10'h30C};

    emb_frame_deser u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .dout    (dout),
        .dvalid  (dvalid),
        .lock_n  (lock_n)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_bit = b;
        nbits++;
    endtask

    task automatic send_raw(input logic [11:0] raw);
        for (int i = 0; i < 12; i++) send_bit(raw[i]);
    endtask

    task automatic send_frame(input logic [9:0] d);
        send_raw({1'b0, d, 1'b1});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Sample one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (lock_n && !ever_locked && (dout !== 10'bz)) z_bad++;
            if (dvalid && lock_n) valid_bad++;
            if (dvalid && ncap < 32) begin
                cap_word[ncap]  = int'(dout);
                cap_stamp[ncap] = nbits;
                ncap++;
            end
            if (prev_lock_n && !lock_n && nfall < 8) begin
                fall_stamp[nfall] = nbits;
                nfall++;
            end
            if (!prev_lock_n && lock_n && nrise < 8) begin
                rise_stamp[nrise] = nbits;
                nrise++;
            end
            if (!lock_n) ever_locked = 1'b1;
            prev_lock_n = lock_n;
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base0, base1, base2;
        int exp_word [16];
        int exp_stamp[16];
        int nexp;

        // Reset state (R2, R3, R9)
        repeat (3) @(posedge clk);
        #1;
        check(lock_n === 1'b1, "R2 reset lock_n", int'(lock_n), 1);
        check(dout === 10'bz, "R3 reset dout floating", int'(dout), 0);
        check(dvalid === 1'b0, "R9 reset dvalid", int'(dvalid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        repeat (5) send_bit(1'b0);

        // Ordinary-data lock: 4 frames with a single 0-to-1 transition (R4)
        base0 = nbits;
        repeat (4) send_frame(10'h007);

        // Walk the vector table (R1, R6)
        nexp = 0;
        for (int i = 0; i < NTBL; i++) begin
            send_frame(TBL[i]);
            exp_word[nexp]  = int'(TBL[i]);
            exp_stamp[nexp] = base0 + 48 + 12 * (i + 1) + 1;
            nexp++;
        end

        // Bad, good, bad, bad (R7, R8)
        base1 = nbits;
        send_raw(12'hFFF);
        send_frame(10'h2A5);
        exp_word[nexp]  = 'h2A5;
        exp_stamp[nexp] = base1 + 25;
        nexp++;
        send_raw(12'hFFF);
        send_raw(12'hFFF);
        send_raw(12'hFFF);
        @(posedge clk);
        #1;
        check(lock_n === 1'b1, "R8 lock_n high while rehunting", int'(lock_n), 1);
        check(dout === 10'h2A5, "R3 dout driven and held after loss", int'(dout), 'h2A5);

        // Sync-frame relock (R5), then words (R6)
        base2 = nbits;
        send_raw(12'h03F);
        for (int i = 0; i < 3; i++) begin
            send_frame(TBL[i]);
            exp_word[nexp]  = int'(TBL[i]);
            exp_stamp[nexp] = base2 + 12 * (i + 1) + 13;
            nexp++;
        end
        send_bit(1'b1);
        send_bit(1'b1);
        @(posedge clk);
        #2;

        check(nfall == 2, "R4 R5 number of lock events", nfall, 2);
        check(fall_stamp[0] == base0 + 49, "R4 random lock timing", fall_stamp[0], base0 + 49);
        check(fall_stamp[1] == base2 + 13, "R5 sync lock timing", fall_stamp[1], base2 + 13);
        check(nrise == 1, "R7 single loss event", nrise, 1);
        check(rise_stamp[0] == base1 + 49, "R8 loss timing", rise_stamp[0], base1 + 49);
        check(ncap == nexp, "R6 R7 word count", ncap, nexp);
        for (int i = 0; i < nexp; i++) begin
            check(cap_word[i] == exp_word[i], "R1 word value", cap_word[i], exp_word[i]);
            check(cap_stamp[i] == exp_stamp[i], "R6 word timing", cap_stamp[i], exp_stamp[i]);
        end
        check(z_bad == 0, "R3 floating before first lock", z_bad, 0);
        check(valid_bad == 0, "R9 no strobe while unlocked", valid_bad, 0);

        finish_run();
    end

endmodule